// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a two-wire bus slave that puts a byte-wide storage array behind an open-drain serial bus. It samples the serial clock and data lines on a fast system clock, recognises bus start and stop conditions, and decodes the address byte that selects the device. It then handles single-byte and multi-byte page writes, and it handles reads from the current address, from a random address, and as a sequential stream. The array is held in on-chip RAM. It holds 2**MEM_AW bytes. The interface is built for a 17-bit word address, and a small default size keeps simulation cheap.

Written data goes into a one-page staging buffer. It is copied into the array only when a stop condition ends the write. After that stop the block acts out a self-timed programming period. For that many system clocks, `busy_o` is high and the block answers no device address, so a bus master can poll for completion. A lock input blocks all array updates. The data line is never driven high: `bus_dat_pull` high means the block pulls the line low.

Top module: `twsee_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. The block changes `bus_dat_pull` only while the clock line is low.
- R2: The device byte is read MSB first as bits[7:3]=10100, bit2 = select bit, bit1 = word-address bit 16, bit0 = direction (1 = read). If bits[7:3] differ, or bit2 differs from `dev_sel`, that byte is not acknowledged and the block ignores the bus until the next start.
- R3: Each accepted device byte, address byte and write-data byte is acknowledged: `bus_dat_pull` is high through the ninth clock pulse.
- R4: The word address is {device bit1, first address byte, second address byte}. The array uses only its low MEM_AW bits, so higher bits alias.
- R5: During a write, the low 8 address bits step by one per data byte and wrap within the same 256-byte page. The upper bits never change, so bytes past the page end land at its start.
- R6: Written bytes reach the array only at a stop. A start or repeated start before that stop discards them, and no programming period follows. After a stop that ends a write holding data, `busy_o` stays high for max(TWR_CYC, 256) system clocks.
- R7: While `busy_o` is high, device bytes are not acknowledged. After it falls they are acknowledged again.
- R8: If `wr_lock` is high when the stop arrives, the array is left unchanged and `busy_o` stays low. Bytes are still acknowledged.
- R9: A read returns the byte at the internal pointer, which holds the last accessed address plus one. This applies after both writes and reads.
- R10: A sequential read goes on while the master acknowledges. Its address steps across pages and wraps from the last array byte to address 0.
- R11: A random read is a write that carries only the address, then a repeated start, then a read. It returns the byte at that address.
- R12: A master non-acknowledge ends a read. The block releases the line and drives nothing until the next start.
- R13: After reset, `bus_dat_pull` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are oversampled on it |
| rst_n | input | 1 | Active-low reset |
| bus_clk_i | input | 1 | Serial bus clock line level |
| bus_dat_i | input | 1 | Serial bus data line level, as seen on the wired bus |
| dev_sel | input | 1 | Strapped select bit compared with device byte bit2 |
| wr_lock | input | 1 | High blocks all array updates |
| bus_dat_pull | output | 1 | High pulls the data line low (open-drain enable) |
| busy_o | output | 1 | High during the timed programming period |

## Verification
A wrong pointer or state in this block shows up on the data line within one byte time. The cases are a missing or misplaced acknowledge, a wrong data bit on the first read after a write, or a bit arriving while the clock line is high. A fault in the staging buffer or the commit walk stays hidden until the next read of that page. For that reason every write is followed by a read that crosses the page wrap and the array wrap. `busy_o` is timed from the stop, so a wrong programming length or a missed lock is visible within a few hundred cycles.

// File: rtl/twsee_pkg.sv
package twsee_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_ACK,
    S_RDAT,
    S_MACK
  } tw_state_e;

  localparam logic [4:0] DEV_TAG = 5'b10100;
endpackage

// File: rtl/twsee_bus_sync.sv
module twsee_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk_i,
  input  logic bus_dat_i,
  output logic clk_lvl,
  output logic dat_lvl,
  output logic clk_rise,
  output logic clk_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_in;
  logic [NLINES-1:0] line_now;
  logic [NLINES-1:0] line_old;

  assign line_in = {bus_dat_i, bus_clk_i};

  // one synchroniser chain per bus line
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain       <= '1;
        line_old[g] <= 1'b1;
      end else begin
        chain       <= {chain[STAGES-2:0], line_in[g]};
        line_old[g] <= chain[STAGES-1];
      end
    end
    assign line_now[g] = chain[STAGES-1];
  end

  assign clk_lvl  = line_now[0];
  assign dat_lvl  = line_now[1];
  assign clk_rise = line_now[0] & ~line_old[0];
  assign clk_fall = ~line_now[0] & line_old[0];
  assign start_ev = line_now[0] & line_old[0] & line_old[1] & ~line_now[1];
  assign stop_ev  = line_now[0] & line_old[0] & ~line_old[1] & line_now[1];
endmodule

// File: rtl/twsee_page_buf.sv
module twsee_page_buf #(
  parameter int PAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           we,
  input  logic [PAW-1:0] woff,
  input  logic [7:0]     wdata,
  input  logic [PAW-1:0] roff,
  output logic [7:0]     rdata,
  output logic           rvalid
);
  localparam int DEPTH = 1 << PAW;

  logic [7:0]       slot [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) slot[woff] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld <= '0;
    else if (clr) vld <= '0;
    else if (we)  vld[woff] <= 1'b1;
  end

  assign rdata  = slot[roff];
  assign rvalid = vld[roff];
endmodule

// File: rtl/twsee_mem.sv
module twsee_mem #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/twsee_slave.sv
module twsee_slave
  import twsee_pkg::*;
#(
  parameter int MEM_AW  = 11,
  parameter int PAGE_AW = 8,
  parameter int TWR_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk_i,
  input  logic bus_dat_i,
  input  logic dev_sel,
  input  logic wr_lock,
  output logic bus_dat_pull,
  output logic busy_o
);
  localparam int PAGE_SZ  = 1 << PAGE_AW;
  localparam int BUSY_CYC = (TWR_CYC > PAGE_SZ) ? TWR_CYC : PAGE_SZ;
  localparam int CW       = $clog2(BUSY_CYC);
  localparam logic [MEM_AW-1:0]  AW_ONE = 1;
  localparam logic [PAGE_AW-1:0] LO_ONE = 1;
  localparam logic [PAGE_AW:0]   CI_ONE = 1;
  localparam logic [CW-1:0]      BC_ONE = 1;

  // address arithmetic kept in functions so it reads as the rule it encodes
  function automatic logic [MEM_AW-1:0] wr_next(input logic [MEM_AW-1:0] a);
    logic [PAGE_AW-1:0] lo;
    lo = a[PAGE_AW-1:0] + LO_ONE;
    return {a[MEM_AW-1:PAGE_AW], lo};
  endfunction

  function automatic logic [MEM_AW-1:0] rd_next(input logic [MEM_AW-1:0] a);
    return a + AW_ONE;
  endfunction

  function automatic logic [MEM_AW-1:0] addr_map(input logic b16, input logic [7:0] hi,
                                                 input logic [7:0] lo);
    return MEM_AW'({b16, hi, lo});
  endfunction

  // bus edge events
  logic clk_lvl, dat_lvl, clk_rise, clk_fall, start_ev, stop_ev;

  twsee_bus_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_clk_i(bus_clk_i),
    .bus_dat_i(bus_dat_i),
    .clk_lvl  (clk_lvl),
    .dat_lvl  (dat_lvl),
    .clk_rise (clk_rise),
    .clk_fall (clk_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  tw_state_e           st, after;
  logic [2:0]          bitcnt;
  logic [7:0]          shreg;
  logic                byte_full;
  logic                sda_low;
  logic                b16_q;
  logic [7:0]          ahi_q;
  logic [MEM_AW-1:0]   ptr;
  logic                wr_pend;
  logic                macked;
  logic                busy;
  logic [CW-1:0]       bcnt;
  logic [PAGE_AW:0]    cidx;
  logic [MEM_AW-PAGE_AW-1:0] cm_page;

  // named internal events
  logic       rx_state, byte_done, dev_hit, data_acc, rd_load, commit_go, commit_we;
  logic [7:0] rx_byte, mem_rdata, pb_rdata;
  logic       pb_rvalid;

  assign rx_state  = (st == S_DEV) || (st == S_AHI) || (st == S_ALO) || (st == S_WDAT);
  assign rx_byte   = {shreg[6:0], dat_lvl};
  assign byte_done = rx_state && clk_rise && !byte_full && (bitcnt == 3'd7);
  assign dev_hit   = (rx_byte[7:3] == DEV_TAG) && (rx_byte[2] == dev_sel) && !busy;
  assign data_acc  = byte_done && (st == S_WDAT);
  assign rd_load   = clk_fall && ((st == S_ACK && after == S_RDAT) || (st == S_MACK && macked));
  assign commit_go = stop_ev && wr_pend && !wr_lock && !busy;
  assign commit_we = busy && !cidx[PAGE_AW] && pb_rvalid;

  twsee_page_buf #(.PAW(PAGE_AW)) u_pbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (byte_done && st == S_ALO),
    .we    (data_acc),
    .woff  (ptr[PAGE_AW-1:0]),
    .wdata (rx_byte),
    .roff  (cidx[PAGE_AW-1:0]),
    .rdata (pb_rdata),
    .rvalid(pb_rvalid)
  );

  twsee_mem #(.AW(MEM_AW)) u_mem (
    .clk  (clk),
    .we   (commit_we),
    .waddr({cm_page, cidx[PAGE_AW-1:0]}),
    .wdata(pb_rdata),
    .raddr(ptr),
    .rdata(mem_rdata)
  );

  // protocol engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      after     <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      byte_full <= 1'b0;
      sda_low   <= 1'b0;
      b16_q     <= 1'b0;
      ahi_q     <= '0;
      ptr       <= '0;
      wr_pend   <= 1'b0;
      macked    <= 1'b0;
    end else if (start_ev) begin
      st        <= S_DEV;
      bitcnt    <= '0;
      byte_full <= 1'b0;
      sda_low   <= 1'b0;
      wr_pend   <= 1'b0;
    end else if (stop_ev) begin
      st        <= S_IDLE;
      byte_full <= 1'b0;
      sda_low   <= 1'b0;
      wr_pend   <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_AHI, S_ALO, S_WDAT: begin
          if (clk_rise && !byte_full) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              byte_full <= 1'b1;
              case (st)
                S_DEV: begin
                  if (dev_hit) begin
                    b16_q <= rx_byte[1];
                    after <= rx_byte[0] ? S_RDAT : S_AHI;
                  end else begin
                    st        <= S_IDLE;
                    byte_full <= 1'b0;
                  end
                end
                S_AHI: begin
                  ahi_q <= rx_byte;
                  after <= S_ALO;
                end
                S_ALO: begin
                  ptr   <= addr_map(b16_q, ahi_q, rx_byte);
                  after <= S_WDAT;
                end
                default: begin
                  ptr     <= wr_next(ptr);
                  wr_pend <= 1'b1;
                  after   <= S_WDAT;
                end
              endcase
            end
          end else if (clk_fall && byte_full) begin
            byte_full <= 1'b0;
            sda_low   <= 1'b1;
            st        <= S_ACK;
          end
        end
        S_ACK: begin
          if (clk_fall) begin
            bitcnt <= '0;
            st     <= after;
            if (after == S_RDAT) begin
              shreg   <= mem_rdata;
              sda_low <= ~mem_rdata[7];
              ptr     <= rd_next(ptr);
            end else begin
              sda_low <= 1'b0;
            end
          end
        end
        S_RDAT: begin
          if (clk_fall) begin
            if (bitcnt == 3'd7) begin
              sda_low <= 1'b0;
              macked  <= 1'b0;
              st      <= S_MACK;
            end else begin
              shreg   <= {shreg[6:0], 1'b0};
              sda_low <= ~shreg[6];
              bitcnt  <= bitcnt + 3'd1;
            end
          end
        end
        S_MACK: begin
          if (clk_rise) begin
            if (!dat_lvl) macked <= 1'b1;
            else          st     <= S_IDLE;
          end else if (clk_fall && macked) begin
            shreg   <= mem_rdata;
            sda_low <= ~mem_rdata[7];
            ptr     <= rd_next(ptr);
            bitcnt  <= '0;
            st      <= S_RDAT;
          end
        end
        default: ;
      endcase
    end
  end

  // timed programming period, walking the page buffer one slot per clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bcnt    <= '0;
      cidx    <= '0;
      cm_page <= '0;
    end else if (commit_go) begin
      busy    <= 1'b1;
      bcnt    <= CW'(BUSY_CYC - 1);
      cidx    <= '0;
      cm_page <= ptr[MEM_AW-1:PAGE_AW];
    end else if (busy) begin
      if (!cidx[PAGE_AW]) cidx <= cidx + CI_ONE;
      if (bcnt == '0) busy <= 1'b0;
      else            bcnt <= bcnt - BC_ONE;
    end
  end

  assign bus_dat_pull = sda_low;
  assign busy_o       = busy;

  // R1: the data line is only moved by the block while the clock line is low
  a_r1_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> !$past(clk_lvl));
  // R3: an acknowledge slot always holds the line low
  a_r3_ack_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK) |-> sda_low);
  // R5: page bits stay fixed while data bytes are accepted
  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> (ptr[MEM_AW-1:PAGE_AW] == $past(ptr[MEM_AW-1:PAGE_AW])));
  // R6: a programming period begins only on a stop
  a_r6_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));
  // R7: nothing is driven while programming
  a_r7_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_low);
  // R8: lock high at the stop suppresses programming
  a_r8_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wr_lock));
  // R10: every read load advances the pointer by one across the whole array
  a_r10_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> (ptr == $past(ptr) + AW_ONE));
  // R12: idle never drives the line
  a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_low);
endmodule

// File: tb/twsee_slave_bench.sv
module twsee_slave_bench;
  localparam int CLK_NS  = 10;
  localparam int Q       = 8 * CLK_NS;
  localparam int BAW     = 11;
  localparam int TWR     = 400;
  localparam int BUSYLEN = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sel = 1'b0;
  logic lock = 1'b0;
  logic dut_pull, dut_busy;
  wire  sda_line = ~(dut_pull | ~m_sda);

  int n_chk = 0;
  int n_err = 0;
  int r1_bad = 0;
  logic prev_pull = 1'b0;
  logic [7:0] model [0:(1<<BAW)-1];

  always #(CLK_NS/2) clk = ~clk;

  twsee_slave #(.MEM_AW(BAW), .PAGE_AW(8), .TWR_CYC(TWR)) u_twsee_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_clk_i   (m_scl),
    .bus_dat_i   (sda_line),
    .dev_sel     (sel),
    .wr_lock     (lock),
    .bus_dat_pull(dut_pull),
    .busy_o      (dut_busy)
  );

  // R1 monitor: the pull must never change while the clock line is high
  always @(negedge clk) begin
    if (rst_n && m_scl && (dut_pull !== prev_pull)) r1_bad++;
    prev_pull <= dut_pull;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q; m_scl = 1'b1; #Q; m_scl = 1'b0; #Q;
    end
    m_sda = 1'b1; #Q; m_scl = 1'b1; #(Q/2);
    ack = ~sda_line;
    #(Q/2); m_scl = 1'b0; #Q;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; m_scl = 1'b1; #(Q/2); b[i] = sda_line; #(Q/2); m_scl = 1'b0;
    end
    m_sda = ~mack; #Q; m_scl = 1'b1; #Q; m_scl = 1'b0; #Q; m_sda = 1'b1;
  endtask

  function automatic logic [7:0] dev_byte(input logic s, input logic b16, input logic rd);
    return {5'b10100, s, b16, rd};
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 5000 && dut_busy; i++) @(negedge clk);
  endtask

  // address phase of a write, acks checked against R3
  task automatic addr_phase(input logic [16:0] a);
    logic ack;
    bus_start();
    wr_byte(dev_byte(sel, a[16], 1'b0), ack); check("R3 device ack", ack, 1);
    wr_byte(a[15:8], ack);                    check("R3 high addr ack", ack, 1);
    wr_byte(a[7:0], ack);                     check("R3 low addr ack", ack, 1);
  endtask

  task automatic write_seq(input logic [16:0] a, input int n, input logic [7:0] d0);
    logic ack;
    addr_phase(a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] lo;
      wr_byte(d0 + 8'(i), ack);
      check("R3 data ack", ack, 1);
      lo = a[7:0] + 8'(i);
      if (!lock) model[{a[BAW-1:8], lo}] = d0 + 8'(i);
    end
    bus_stop();
  endtask

  task automatic read_seq(input logic [16:0] a, input int n, input string req);
    logic ack;
    logic [7:0] b;
    logic [BAW-1:0] idx;
    addr_phase(a);
    bus_start();
    wr_byte(dev_byte(sel, a[16], 1'b1), ack);
    check("R11 read device ack", ack, 1);
    idx = a[BAW-1:0];
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, b);
      check(req, b, model[idx]);
      idx = idx + 1'b1;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    check("R13 pull low after reset", dut_pull, 0);
    check("R13 busy low after reset", dut_busy, 0);
  endtask

  task automatic t_byte_write_poll();
    logic ack;
    write_seq(17'h00010, 1, 8'hA5);
    check("R6 busy after stop", dut_busy, 1);
    bus_start();
    wr_byte(dev_byte(sel, 1'b0, 1'b0), ack);
    check("R7 no ack while busy", ack, 0);
    bus_stop();
    wait_idle();
    bus_start();
    wr_byte(dev_byte(sel, 1'b0, 1'b0), ack);
    check("R7 ack after busy", ack, 1);
    bus_stop();
    #Q;
    check("R6 no busy without data", dut_busy, 0);
  endtask

  task automatic t_random_read();
    read_seq(17'h00010, 1, "R11 random read");
  endtask

  task automatic t_current_read();
    logic ack;
    logic [7:0] b;
    int cnt;
    write_seq(17'h00120, 4, 8'h30);
    cnt = 0;
    while (dut_busy && cnt < 5000) begin @(negedge clk); cnt++; end
    check("R6 programming length", (cnt >= BUSYLEN - 16 && cnt <= BUSYLEN), 1);
    read_seq(17'h00120, 1, "R11 read page start");
    bus_start();
    wr_byte(dev_byte(sel, 1'b0, 1'b1), ack);
    rd_byte(1'b0, b);
    bus_stop();
    check("R9 current address read", b, model[11'h121]);
  endtask

  task automatic t_page_wrap();
    write_seq(17'h00400, 1, 8'h5C); wait_idle();
    write_seq(17'h003FE, 4, 8'h11); wait_idle();
    check("R5 wrap lands at page start", model[11'h300], 8'h13);
    read_seq(17'h003FE, 3, "R10 read crosses page");
    read_seq(17'h00300, 2, "R5 wrapped bytes");
  endtask

  task automatic t_array_wrap();
    write_seq(17'h007FF, 1, 8'hE1); wait_idle();
    write_seq(17'h00000, 1, 8'h1E); wait_idle();
    read_seq(17'h007FF, 2, "R10 array wrap");
  endtask

  task automatic t_alias();
    write_seq(17'h10155, 1, 8'h6B); wait_idle();
    read_seq(17'h00155, 1, "R4 high bits alias");
  endtask

  task automatic t_discard();
    logic ack;
    write_seq(17'h00200, 1, 8'h42); wait_idle();
    addr_phase(17'h00200);
    wr_byte(8'h99, ack);
    bus_start();
    bus_stop();
    #Q;
    check("R6 discarded write no busy", dut_busy, 0);
    read_seq(17'h00200, 1, "R6 discarded write keeps data");
  endtask

  task automatic t_lock();
    write_seq(17'h00210, 1, 8'h10); wait_idle();
    lock = 1'b1;
    write_seq(17'h00210, 1, 8'h77);
    #Q;
    check("R8 lock no busy", dut_busy, 0);
    lock = 1'b0;
    read_seq(17'h00210, 1, "R8 lock keeps data");
  endtask

  task automatic t_mismatch();
    logic ack;
    bus_start();
    wr_byte(dev_byte(~sel, 1'b0, 1'b0), ack);
    check("R2 wrong select no ack", ack, 0);
    wr_byte(8'h00, ack);
    check("R2 ignored after mismatch", ack, 0);
    bus_stop();
    bus_start();
    wr_byte(8'hB0, ack);
    check("R2 wrong prefix no ack", ack, 0);
    bus_stop();
    check("R2 no busy", dut_busy, 0);
  endtask

  task automatic t_nack_end();
    logic ack;
    logic [7:0] b;
    read_seq(17'h00010, 1, "R12 read before nack");
    bus_start();
    wr_byte(dev_byte(sel, 1'b0, 1'b1), ack);
    rd_byte(1'b0, b);
    rd_byte(1'b0, b);
    check("R12 line released after nack", b, 8'hFF);
    bus_stop();
    read_seq(17'h00010, 1, "R12 new read after stop");
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_byte_write_poll();
    t_random_read();
    t_current_read();
    t_page_wrap();
    t_array_wrap();
    t_alias();
    t_discard();
    t_lock();
    t_mismatch();
    t_nack_end();
    check("R1 pull moved only with clock low", r1_bad, 0);
    report();
  end
endmodule